// File: doc/BRIEF.md
# Clock Domain Source Selector and Divider

This block produces the clock for one clock domain. One 32-bit configuration register, written and read over a plain single-cycle register port, chooses one of five source clocks and sets a divider. The divider has two separate counts, one for the high phase and one for the low phase of the output, so the duty cycle can be set as well as the ratio. A bypass bit passes the chosen source through undivided.

Every clock is modelled as an enable on a single system clock. A source "edge" is a one-cycle pulse on its tick input. The domain output is a level signal that changes only on ticks of the active source. Two status bits let software poll for the end of a source change or of a divider update. A count-width parameter fixes the divider range, so a narrower domain such as a memory domain can be built from the same code.

Top module: `clk_domain_gen`

## Requirements
- R1: While reset is applied and just after it, the register reads 0x00000001. This means source 1 (oscillator), no bypass, wait and hold counts 0 and both status bits 0. The domain output is 0 while reset is applied.
- R2: Register bits [2:0] pick the source tick input: 0 is the RTC tick, 1 the oscillator tick, and 2, 3 and 4 the three PLL ticks. After a switch completes, the output timing follows the newly picked input.
- R3: A write whose bits [2:0] hold 5, 6 or 7 leaves the source field and the active source unchanged, and it starts no switch.
- R4: After a write that changes the source, bit 3 reads 1 and the output stays 0. Bit 3 goes back to 0 on exactly the second tick of the new source.
- R5: With wait count W and hold count H in effect, the output is high for W+1 source ticks and low for H+1 source ticks, so its period is W+H+2 ticks.
- R6: The wait count sits in bits [19:16] and the hold count in bits [23:20]. Both read back as written. A write with bit 25 clear does not change the division in use.
- R7: Writing 1 to bit 25 applies the written counts. Bit 25 reads 1 until the counts take effect at the end of a low phase. It clears in the same cycle that the output rises.
- R8: With bit 24 set, the output equals the tick of the active source: high for one cycle on every tick.
- R9: With the default count width N = 4, counts of 15 and 15 give the largest ratio, 2^(N+1) = 32. These counts read back as 0xF.
- R10: For a ratio R, counts W = R/2 - 1 and H = R - W - 2 give a period of R ticks. For the odd ratio 5 that is 2 ticks high and 3 low.
- R11: Ticks on inputs other than the active source have no effect. If the active source stops ticking, the output holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_tick | input | 5 | One-cycle tick per source clock (index = source code) |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, including status bits |
| dom_clk | output | 1 | Domain clock output level |

## Verification
The assertions assume that each source tick lasts one system cycle. They also assume that the active source keeps ticking, because a switch or a commit only completes on ticks of that source. The stimulus drives every source from a free-running generator with a fixed period of two system cycles or more. It stops a source only in the one check that requires it, and then starts it again. Register writes last one cycle and are applied between ticks, away from the sampling edge.

// File: rtl/cdd_pkg.sv
package cdd_pkg;
  localparam int NSRC     = 5;
  localparam int SRC_W    = 3;
  localparam int REG_W    = 32;
  localparam int SETTLE   = 2;
  localparam int SEEN_W   = $clog2(SETTLE + 1);
  localparam int BUSY_BIT = 3;
  localparam int WAIT_LSB = 16;
  localparam int HOLD_LSB = 20;
  localparam int BYP_BIT  = 24;
  localparam int CMT_BIT  = 25;
  localparam logic [SRC_W-1:0] SRC_LAST = SRC_W'(NSRC - 1);

  typedef enum logic [SRC_W-1:0] {
    SRC_RTC   = 3'd0,
    SRC_OSC   = 3'd1,
    SRC_PLL_A = 3'd2,
    SRC_PLL_B = 3'd3,
    SRC_PLL_C = 3'd4
  } src_e;
endpackage

// File: rtl/cdd_cfg_reg.sv
module cdd_cfg_reg
  import cdd_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic             busy,
  input  logic             ack,
  output logic [SRC_W-1:0] src_q,
  output logic [CNT_W-1:0] wait_q,
  output logic [CNT_W-1:0] hold_q,
  output logic             byp_q,
  output logic             pend_q,
  output logic [REG_W-1:0] rdata
);
  localparam logic [REG_W-1:0] USED_MASK =
      (REG_W'((1 << SRC_W) - 1)) |
      (REG_W'((1 << CNT_W) - 1) << WAIT_LSB) |
      (REG_W'((1 << CNT_W) - 1) << HOLD_LSB) |
      (REG_W'(1) << BYP_BIT) | (REG_W'(1) << CMT_BIT);

  logic [SRC_W-1:0] src_d;
  logic [CNT_W-1:0] wait_d, hold_d;
  logic             byp_d, pend_d, src_ok;
  logic             spare_bits_unused;

  assign spare_bits_unused = ^(wdata & ~USED_MASK);
  assign src_ok = (wdata[SRC_W-1:0] <= SRC_LAST);

  always_comb begin
    src_d  = src_q;
    wait_d = wait_q;
    hold_d = hold_q;
    byp_d  = byp_q;
    pend_d = pend_q;
    if (ack) pend_d = 1'b0;
    if (we) begin
      if (src_ok) src_d = wdata[SRC_W-1:0];
      wait_d = wdata[WAIT_LSB +: CNT_W];
      hold_d = wdata[HOLD_LSB +: CNT_W];
      byp_d  = wdata[BYP_BIT];
      if (wdata[CMT_BIT]) pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_OSC;
      wait_q <= '0;
      hold_q <= '0;
      byp_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      src_q  <= src_d;
      wait_q <= wait_d;
      hold_q <= hold_d;
      byp_q  <= byp_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    rdata = '0;
    rdata[SRC_W-1:0]          = src_q;
    rdata[BUSY_BIT]           = busy;
    rdata[WAIT_LSB +: CNT_W]  = wait_q;
    rdata[HOLD_LSB +: CNT_W]  = hold_q;
    rdata[BYP_BIT]            = byp_q;
    rdata[CMT_BIT]            = pend_q;
  end

  // R3: an out-of-range source code never reaches the source field
  p_bad_src_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !src_ok) |=> (src_q == $past(src_q)));
  // R7: a commit request is visible at once
  p_commit_seen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata[CMT_BIT]) |=> pend_q);
  // R7: the request only drops when the divider has taken the counts
  p_commit_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> $past(ack));
endmodule

// File: rtl/cdd_src_switch.sv
module cdd_src_switch
  import cdd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] target,
  input  logic [NSRC-1:0]  src_tick,
  output logic [SRC_W-1:0] cur_q,
  output logic             busy,
  output logic             sel_tick
);
  logic [SRC_W-1:0]  cur_d, last_q;
  logic [SEEN_W-1:0] seen_q, seen_d;
  logic              tgt_tick, cur_tick;

  always_comb begin
    tgt_tick = 1'b0;
    cur_tick = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (target == SRC_W'(i)) tgt_tick = src_tick[i];
      if (cur_q  == SRC_W'(i)) cur_tick = src_tick[i];
    end
  end

  assign busy     = (target != cur_q);
  assign sel_tick = busy ? 1'b0 : cur_tick;

  always_comb begin
    cur_d  = cur_q;
    seen_d = seen_q;
    if (!busy || (target != last_q)) begin
      seen_d = '0;
    end else if (tgt_tick) begin
      if (seen_q == SEEN_W'(SETTLE - 1)) begin
        cur_d  = target;
        seen_d = '0;
      end else begin
        seen_d = seen_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= SRC_OSC;
      last_q <= SRC_OSC;
      seen_q <= '0;
    end else begin
      cur_q  <= cur_d;
      last_q <= target;
      seen_q <= seen_d;
    end
  end

  // R2: the active source is always one of the five inputs
  p_cur_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q <= SRC_LAST);
  // R4: the active source only moves on a tick of the requested one
  p_switch_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q != $past(cur_q)) |-> ($past(tgt_tick) && (cur_q == $past(target))));
  // R4: the settle counter never passes its limit
  p_seen_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q < SEEN_W'(SETTLE));
endmodule

// File: rtl/cdd_divider.sv
module cdd_divider #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             park,
  input  logic [CNT_W-1:0] wait_cfg,
  input  logic [CNT_W-1:0] hold_cfg,
  input  logic             pend,
  output logic             phase_q,
  output logic             ack
);
  logic             phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, w_act, w_d, h_act, h_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    w_d     = w_act;
    h_d     = h_act;
    ack     = 1'b0;
    if (park) begin
      phase_d = 1'b0;
      cnt_d   = h_act;
    end else if (tick) begin
      if (phase_q) begin
        if (cnt_q == w_act) begin
          phase_d = 1'b0;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == h_act) begin
          phase_d = 1'b1;
          cnt_d   = '0;
          if (pend) begin
            w_d = wait_cfg;
            h_d = hold_cfg;
            ack = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
      w_act   <= '0;
      h_act   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      w_act   <= w_d;
      h_act   <= h_d;
    end
  end

  // R11: the output level only moves on a source tick or while parked
  p_edge_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != $past(phase_q)) |-> $past(tick || park));
  // R7: new counts start a fresh high phase
  p_load_fresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ack) |-> (phase_q && (cnt_q == '0)));
  // R5: phase counters stay within the active counts
  p_high_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q |-> (cnt_q <= w_act));
  p_low_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_q |-> (cnt_q <= h_act));
endmodule

// File: rtl/clk_domain_gen.sv
module clk_domain_gen
  import cdd_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       src_tick,
  input  logic             cfg_we,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  output logic             dom_clk
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [SRC_W-1:0] src_field, cur_src;
  logic [CNT_W-1:0] wait_q, hold_q;
  logic             byp_q, pend_q, busy, sel_tick, div_phase, ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cdd_cfg_reg #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .we(cfg_we), .wdata(cfg_wdata),
    .busy(busy), .ack(ack), .src_q(src_field), .wait_q(wait_q),
    .hold_q(hold_q), .byp_q(byp_q), .pend_q(pend_q), .rdata(cfg_rdata)
  );

  cdd_src_switch u_sw (
    .clk(clk), .rst_n(rst_int_n), .target(src_field), .src_tick(src_tick),
    .cur_q(cur_src), .busy(busy), .sel_tick(sel_tick)
  );

  cdd_divider #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_int_n), .tick(sel_tick), .park(busy),
    .wait_cfg(wait_q), .hold_cfg(hold_q), .pend(pend_q),
    .phase_q(div_phase), .ack(ack)
  );

  assign dom_clk = byp_q ? sel_tick : (div_phase & ~busy);

  // R4: nothing reaches the domain while a source change is under way
  p_busy_quiet_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy |-> !dom_clk);
  // R2: the register field and the active source agree whenever idle
  p_idle_match_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cfg_rdata[BUSY_BIT] |-> (cur_src == cfg_rdata[SRC_W-1:0]));
endmodule

// File: tb/clk_domain_gen_bench.sv
module clk_domain_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  src_tick;
  logic [4:0]  mask;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        dom_clk;

  typedef struct { string req; int exp; } exp_t;
  exp_t sb_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  int   per[5] = '{8, 3, 2, 4, 5};
  int   tcnt[5];

  always #5 clk = ~clk;

  clk_domain_gen u_clk_domain_gen (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dom_clk(dom_clk)
  );

  // free-running source tick generator
  initial begin
    src_tick = '0;
    mask     = '1;
    for (int i = 0; i < 5; i++) tcnt[i] = 0;
    forever begin
      @(posedge clk);
      for (int i = 0; i < 5; i++) begin
        if (tcnt[i] == per[i] - 1) begin
          tcnt[i] = 0;
          src_tick[i] <= mask[i];
        end else begin
          tcnt[i] = tcnt[i] + 1;
          src_tick[i] <= 1'b0;
        end
      end
    end
  end

  task automatic push_exp(string req, int v);
    exp_t e;
    e.req = req;
    e.exp = v;
    sb_q.push_back(e);
  endtask

  task automatic pop_cmp(int act);
    exp_t e;
    e = sb_q.pop_front();
    n_vec++;
    if (act != e.exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", e.req, act, e.exp);
    end
  endtask

  task automatic check(string req, int act, int exp);
    push_exp(req, exp);
    pop_cmp(act);
  endtask

  function automatic logic [31:0] mk(int s, int w, int h, bit b, bit c);
    logic [31:0] v;
    v = '0;
    v[2:0]   = s[2:0];
    v[19:16] = w[3:0];
    v[23:20] = h[3:0];
    v[24]    = b;
    v[25]    = c;
    return v;
  endfunction

  task automatic wr(logic [31:0] d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // driver side pushes expected run lengths, monitor side measures and pops
  task automatic measure(string req, int hi_exp, int lo_exp);
    logic prev;
    int   hi, lo;
    push_exp(req, hi_exp);
    push_exp(req, lo_exp);
    @(negedge clk);
    prev = dom_clk;
    @(negedge clk);
    while (!(prev == 1'b0 && dom_clk == 1'b1)) begin
      prev = dom_clk;
      @(negedge clk);
    end
    hi = 0;
    while (dom_clk) begin hi++; @(negedge clk); end
    lo = 0;
    while (!dom_clk) begin lo++; @(negedge clk); end
    pop_cmp(hi);
    pop_cmp(lo);
  endtask

  task automatic wait_commit(string req);
    while (cfg_rdata[25]) @(negedge clk);
    check(req, int'(dom_clk), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int ticks;
    int cyc;
    int low_ok;
    int changes;
    logic v;
    rst_n     = 1'b0;
    cfg_we    = 1'b0;
    cfg_wdata = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 reset rdata", int'(cfg_rdata), 32'h00000001);
    check("R1 reset output", int'(dom_clk), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 rdata after release", int'(cfg_rdata), 32'h00000001);

    // R5: default divide by 2 on the oscillator (period 3)
    measure("R5 default ratio", 3, 3);

    // R6: counts written without commit read back but do not apply
    wr(mk(1, 2, 1, 0, 0));
    check("R6 readback", int'(cfg_rdata), 32'h00120001);
    measure("R6 no commit keeps ratio", 3, 3);

    // R7: commit applies at end of a low phase
    wr(mk(1, 2, 1, 0, 1));
    check("R7 commit pending", int'(cfg_rdata[25]), 1);
    wait_commit("R7 clears on rise");
    measure("R5 W2 H1", 9, 6);

    // R10: ratio 5 -> W1 H2
    wr(mk(1, 1, 2, 0, 1));
    wait_commit("R10 commit done");
    measure("R10 ratio 5", 6, 9);

    // R3: invalid source code ignored
    wr(mk(7, 1, 2, 0, 0));
    check("R3 source kept", int'(cfg_rdata[2:0]), 1);
    check("R3 no busy", int'(cfg_rdata[3]), 0);
    measure("R3 output unchanged", 6, 9);

    // R11: stop the active source, others keep ticking
    mask[1] = 1'b0;
    repeat (4) @(negedge clk);
    v = dom_clk;
    changes = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (dom_clk != v) changes++;
    end
    check("R11 output holds", changes, 0);
    mask[1] = 1'b1;

    // R8: bypass passes the oscillator tick (period 3)
    wr(mk(1, 1, 2, 1, 0));
    measure("R8 bypass", 1, 2);

    // R4: switch to source 2 (period 2)
    wr(mk(2, 1, 2, 0, 0));
    check("R4 busy set", int'(cfg_rdata[3]), 1);
    ticks  = 0;
    cyc    = 0;
    low_ok = 1;
    while (cfg_rdata[3] && cyc < 100) begin
      if (dom_clk) low_ok = 0;
      if (src_tick[2]) ticks++;
      cyc++;
      @(negedge clk);
    end
    check("R4 ticks while busy", ticks, 2);
    check("R4 output low while busy", low_ok, 1);
    check("R2 source field", int'(cfg_rdata[2:0]), 2);
    measure("R2 source 2 timing", 4, 6);

    // R2: switch to source 0 (period 8)
    wr(mk(0, 1, 2, 0, 0));
    while (cfg_rdata[3]) @(negedge clk);
    measure("R2 source 0 timing", 16, 24);

    // R9: largest ratio on source 2
    wr(mk(2, 15, 15, 0, 1));
    wait_commit("R9 commit done");
    check("R9 wait readback", int'(cfg_rdata[19:16]), 15);
    check("R9 hold readback", int'(cfg_rdata[23:20]), 15);
    measure("R9 ratio 32", 32, 32);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule